// File: doc/BRIEF.md
# ADC Conversion Start Selector

This block decides when a successive-approximation converter should begin a conversion. It watches four peripheral event flags and the converter's own completion flag. A select code picks one of these lines, and the block watches that line for a rising edge. When the edge arrives and automatic triggering is enabled, the block issues a one-clock start pulse. A software-style manual request can also start a conversion at any time, and it does not depend on the automatic settings.

The edge detector sits after the source multiplexer. Because of this, moving the select from a low line to a high line counts as a rising edge. The single exception is a move into the free-running code: that move is blocked, even when the completion flag is already high. In free-running mode, every completion edge requests the next conversion. A manual request starts the first conversion in that chain.

A start is only issued when the converter is enabled and idle. A request that arrives while a conversion is busy is dropped and not held for later. The asynchronous reset is released in step with the clock through a two-stage synchroniser.

Top module: `adc_autotrig_sel`

## Requirements
- R1: The select code chooses the watched line: 0 = `conv_done`, 1 = `evt_flags[0]` (comparator), 2 = `evt_flags[1]` (external interrupt 0), 3 = `evt_flags[2]` (timer 0 compare A), 4 = `evt_flags[3]` (timer 0 overflow). A low-to-high change of the chosen line, sampled on one clock edge, raises `start_conv` for the clock cycle after that edge.
- R2: While `auto_en` is low, no edge and no select change produces a start. The edge register still follows the chosen line, so a line that stays high does not fire when `auto_en` later rises.
- R3: Changing the select from a code whose line is low to a code whose line is high produces a start, with the same timing as R1.
- R4: Changing the select from any nonzero code to code 0 never produces a start, even if `conv_done` is high at that moment.
- R5: No start is issued while `adc_en` is low. A line that rose during that time does not fire when `adc_en` is later set.
- R6: A trigger or manual request that arrives while `conv_busy` is high is dropped. It does not fire after `conv_busy` falls.
- R7: `start_conv` is never high on two consecutive cycles. If an automatic edge and a manual request fall in the same cycle, they give one pulse.
- R8: Select codes 5, 6 and 7 watch no line and never produce an automatic start.
- R9: `manual_start` with `adc_en` high and `conv_busy` low produces a start on the next cycle, whatever `auto_en` and the select code are.
- R10: In code 0, each rising edge of `conv_done` produces the next start, and a manual request begins the chain.
- R11: While reset is asserted, `start_conv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| adc_en | input | 1 | Converter enable; gates every start |
| auto_en | input | 1 | Enables automatic starts from the selected line |
| src_sel | input | 3 | Trigger source code |
| evt_flags | input | 4 | Peripheral event flags: comparator, external interrupt 0, timer compare A, timer overflow |
| conv_done | input | 1 | Converter completion flag; the free-running source |
| conv_busy | input | 1 | High while a conversion is in progress |
| manual_start | input | 1 | Direct start request |
| start_conv | output | 1 | One-clock start pulse |

## Verification
Two cases can fall in the same cycle. The first is an automatic edge together with a manual request: the bench raises the comparator flag and `manual_start` before the same clock edge. It expects exactly one pulse, then a low cycle even though the manual request is still held. The second is the blocked switch into free-running mode together with a completion flag that is already high: the bench changes `src_sel` to 0 and raises `conv_done` at the same time. It judges the result by seeing no pulse on that cycle or the next. A later real completion edge must still start a conversion.

// File: rtl/adc_autotrig_pkg.sv
package adc_autotrig_pkg;

  // Source codes; the numeric values are decoded by the selector.
  typedef enum logic [2:0] {
    SRC_FREE_RUN = 3'd0,
    SRC_ACOMP    = 3'd1,
    SRC_EXTINT0  = 3'd2,
    SRC_TMR_CMPA = 3'd3,
    SRC_TMR_OVF  = 3'd4
  } trig_src_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/adc_trig_rst_sync.sv
module adc_trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/adc_trig_src_mux.sv
module adc_trig_src_mux #(
  parameter int unsigned N_EVT = 4,
  parameter int unsigned SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N_EVT-1:0] evt,
  input  logic             done,
  output logic             level
);

  import adc_autotrig_pkg::*;

  logic [N_EVT-1:0] hit;

  // One decoder per event line, code i+1 selects evt[i].
  for (genvar g = 0; g < N_EVT; g++) begin : g_dec
    assign hit[g] = (sel == SEL_W'(g + 1)) & evt[g];
  end

  always_comb begin
    level = |hit;
    if (sel == SEL_W'(SRC_FREE_RUN)) level = done;
  end

endmodule

// File: rtl/adc_trig_edge_det.sv
module adc_trig_edge_det #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             level,
  output logic             rise,
  output logic             into_free
);

  logic             lvl_q, lvl_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             smp_en;

  // Sampling runs every cycle, independent of any enable.
  assign smp_en = 1'b1;

  always_comb begin
    lvl_d = lvl_q;
    sel_d = sel_q;
    if (smp_en) begin
      lvl_d = level;
      sel_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      sel_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      sel_q <= sel_d;
    end
  end

  assign rise      = level & ~lvl_q;
  assign into_free = (sel == '0) & (sel_q != '0);

endmodule

// File: rtl/adc_trig_start_gen.sv
module adc_trig_start_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic adc_en,
  input  logic auto_en,
  input  logic rise,
  input  logic into_free,
  input  logic manual,
  input  logic busy,
  output logic start
);

  logic start_q, start_d;
  logic auto_req, any_req, can_go;

  always_comb begin
    auto_req = auto_en & rise & ~into_free;
    any_req  = auto_req | manual;
    can_go   = adc_en & ~busy & ~start_q;
    start_d  = any_req & can_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  assign start = start_q;

endmodule

// File: rtl/adc_autotrig_sel.sv
module adc_autotrig_sel #(
  parameter int unsigned N_EVT = 4,
  localparam int unsigned SEL_W = $clog2(N_EVT + 1)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             adc_en,
  input  logic             auto_en,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [N_EVT-1:0] evt_flags,
  input  logic             conv_done,
  input  logic             conv_busy,
  input  logic             manual_start,
  output logic             start_conv
);

  import adc_autotrig_pkg::*;

  logic rst_q_n;
  logic sel_level;
  logic sel_rise;
  logic sel_into_free;

  adc_trig_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_q_n)
  );

  adc_trig_src_mux #(.N_EVT(N_EVT), .SEL_W(SEL_W)) u_mux (
    .sel   (src_sel),
    .evt   (evt_flags),
    .done  (conv_done),
    .level (sel_level)
  );

  adc_trig_edge_det #(.SEL_W(SEL_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .sel       (src_sel),
    .level     (sel_level),
    .rise      (sel_rise),
    .into_free (sel_into_free)
  );

  adc_trig_start_gen u_start (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .adc_en    (adc_en),
    .auto_en   (auto_en),
    .rise      (sel_rise),
    .into_free (sel_into_free),
    .manual    (manual_start),
    .busy      (conv_busy),
    .start     (start_conv)
  );

endmodule

// File: rtl/adc_autotrig_chk.sv
module adc_autotrig_chk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_en,
  input logic             auto_en,
  input logic [SEL_W-1:0] src_sel,
  input logic             conv_busy,
  input logic             manual_start,
  input logic             start_conv
);

  logic [SEL_W-1:0] sel_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= '0;
    else        sel_prev <= src_sel;
  end

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv);

  assert_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> $past(adc_en));

  assert_busy_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> !$past(conv_busy));

  assert_auto_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(auto_en) && !$past(manual_start)) |-> !start_conv);

  assert_dead_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) > SEL_W'(4) && !$past(manual_start)) |-> !start_conv);

  assert_no_free_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel) == '0 && $past(sel_prev) != '0 && !$past(manual_start))
      |-> !start_conv);

  assert_manual_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(manual_start && adc_en && !conv_busy && !start_conv) |-> start_conv);

endmodule

bind adc_autotrig_sel adc_autotrig_chk #(.SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .adc_en       (adc_en),
  .auto_en      (auto_en),
  .src_sel      (src_sel),
  .conv_busy    (conv_busy),
  .manual_start (manual_start),
  .start_conv   (start_conv)
);

// File: tb/sim_adc_autotrig_sel.sv
module sim_adc_autotrig_sel;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       adc_en, auto_en, conv_done, conv_busy, manual_start;
  logic [2:0] src_sel;
  logic [3:0] evt_flags;
  logic       start_conv;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  adc_autotrig_sel u0 (
    .clk          (clk),
    .arst_n       (arst_n),
    .adc_en       (adc_en),
    .auto_en      (auto_en),
    .src_sel      (src_sel),
    .evt_flags    (evt_flags),
    .conv_done    (conv_done),
    .conv_busy    (conv_busy),
    .manual_start (manual_start),
    .start_conv   (start_conv)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic exp);
    n_run++;
    if (start_conv !== exp) begin
      n_fail++;
      $display("FAIL %s: start_conv actual %b expected %b", tag, start_conv, exp);
    end
  endtask

  task automatic settle(input logic [2:0] s);
    manual_start = 1'b0; evt_flags = '0; conv_done = 1'b0; conv_busy = 1'b0;
    adc_en = 1'b1; auto_en = 1'b1; src_sel = s;
    cyc(); cyc();
  endtask

  task automatic t_reset();
    arst_n = 1'b0; adc_en = 1'b1; auto_en = 1'b1; src_sel = 3'd1;
    evt_flags = 4'hF; conv_done = 1'b1; conv_busy = 1'b0; manual_start = 1'b1;
    cyc(); cyc();
    chk("R11 reset", 1'b0);
    cyc();
    chk("R11 reset held", 1'b0);
    manual_start = 1'b0; evt_flags = '0; conv_done = 1'b0;
    arst_n = 1'b1;
    repeat (4) cyc();
  endtask

  task automatic t_sources();
    for (int c = 1; c <= 4; c++) begin
      settle(3'(c));
      chk("R1 quiet", 1'b0);
      evt_flags[c-1] = 1'b1;
      cyc();
      chk($sformatf("R1 code %0d edge", c), 1'b1);
      cyc();
      chk("R7 level held no repeat", 1'b0);
    end
  endtask

  task automatic t_free_run();
    settle(3'd4);
    src_sel = 3'd0; conv_done = 1'b1;
    cyc();
    chk("R4 entry blocked", 1'b0);
    cyc();
    chk("R4 entry blocked later", 1'b0);
    conv_done = 1'b0;
    cyc();
    manual_start = 1'b1;
    cyc();
    chk("R10 manual kick", 1'b1);
    manual_start = 1'b0;
    cyc();
    chk("R10 idle", 1'b0);
    conv_done = 1'b1;
    cyc();
    chk("R10 done edge restarts", 1'b1);
    conv_done = 1'b0;
    cyc();
    conv_done = 1'b1;
    cyc();
    chk("R10 second restart", 1'b1);
  endtask

  task automatic t_reselect();
    settle(3'd1);
    evt_flags = 4'b0010;
    cyc();
    chk("R3 low source quiet", 1'b0);
    src_sel = 3'd2;
    cyc();
    chk("R3 reselect to high line", 1'b1);
    src_sel = 3'd1;
    cyc();
    chk("R3 back to low line", 1'b0);
    src_sel = 3'd2;
    cyc();
    chk("R3 reselect again", 1'b1);
  endtask

  task automatic t_auto_off();
    settle(3'd1);
    auto_en = 1'b0;
    evt_flags = 4'b0001;
    cyc();
    chk("R2 edge ignored", 1'b0);
    evt_flags = 4'b0011;
    src_sel = 3'd2;
    cyc();
    chk("R2 reselect ignored", 1'b0);
    auto_en = 1'b1;
    cyc();
    chk("R2 held line no late fire", 1'b0);
    manual_start = 1'b1; auto_en = 1'b0;
    cyc();
    chk("R9 manual with auto off", 1'b1);
    manual_start = 1'b0;
  endtask

  task automatic t_disabled();
    settle(3'd3);
    adc_en = 1'b0;
    evt_flags = 4'b0100;
    cyc();
    chk("R5 disabled edge", 1'b0);
    adc_en = 1'b1;
    cyc();
    chk("R5 not held over", 1'b0);
  endtask

  task automatic t_busy();
    settle(3'd1);
    conv_busy = 1'b1;
    evt_flags = 4'b0001;
    cyc();
    chk("R6 edge while busy", 1'b0);
    conv_busy = 1'b0;
    cyc();
    chk("R6 not queued", 1'b0);
    conv_busy = 1'b1; manual_start = 1'b1;
    cyc();
    chk("R6 manual while busy", 1'b0);
    manual_start = 1'b0; conv_busy = 1'b0;
    cyc();
    chk("R6 manual not queued", 1'b0);
  endtask

  task automatic t_dead_codes();
    for (int c = 5; c <= 7; c++) begin
      settle(3'(c));
      evt_flags = 4'hF; conv_done = 1'b1;
      cyc();
      chk($sformatf("R8 code %0d silent", c), 1'b0);
    end
    evt_flags = '0; conv_done = 1'b0;
    cyc();
  endtask

  task automatic t_coincide();
    settle(3'd1);
    evt_flags = 4'b0001; manual_start = 1'b1;
    cyc();
    chk("R7 coincident one pulse", 1'b1);
    cyc();
    chk("R7 gap after pulse", 1'b0);
    manual_start = 1'b0;
    cyc();
  endtask

  initial begin
    #(200000 * 4);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_sources();
    t_free_run();
    t_reselect();
    t_auto_off();
    t_disabled();
    t_busy();
    t_dead_codes();
    t_coincide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule